// File: doc/BRIEF.md
# Row/Column Slice Matrix Store

This block holds a square matrix of fixed-width words and lets a client move a whole row or a whole column in one clock cycle, in either direction. The storage is not a flat register array. It is split into one single-port memory bank per matrix dimension. Each element is placed in a bank chosen by its diagonal, (column − row) mod DIM, and at an address equal to its row. With this skew, every row and every column touches each bank exactly once, so all banks can work in parallel on any row or column access.

A command carries a read strobe, a write strobe, an axis bit (row or column) and a slice index. For a write, a scatter network reorders the incoming lane vector into bank order. For a read, a gather network puts the bank outputs back into natural element order, one cycle later. An address generator gives each bank its own address for the selected slice. A read and a write may be issued together. Because the banks read before they write, the read returns the slice as it was before that write.

Top module: `skew_matrix`

## Requirements
- R1: After a row write of index r with lane vector V, a later row read of index r returns V, with lane j equal to V lane j, for every r in 0..DIM-1.
- R2: After a column write of index c with lane vector V, a later column read of index c returns V, with lane j equal to V lane j.
- R3: Row and column views are consistent: lane r of a column read of c equals lane c of a row read of r, whichever axis last wrote that element.
- R4: A row or column write changes only the DIM elements of that slice. All other elements keep their values.
- R5: rd_valid is 1 exactly in the cycle after a cycle with cmd_rd = 1, and rd_data carries the requested slice in that cycle.
- R6: When cmd_rd and cmd_wr are both 1 in the same cycle, the read returns the slice contents from before that write. A subsequent read returns the newly written data.
- R7: rd_data holds its value in any cycle that follows a cycle without a read command.
- R8: A synchronous active-high rst makes rd_valid 0 on the next clock edge. Matrix contents are not initialised by reset.
- R9: A write with cmd_rd = 0 does not raise rd_valid and does not change rd_data.
- R10: Lane j of wr_data and rd_data occupies bits [j*WIDTH +: WIDTH]. cmd_col = 0 selects a row and cmd_col = 1 selects a column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (clears rd_valid) |
| cmd_rd | input | 1 | Read the selected slice |
| cmd_wr | input | 1 | Write wr_data into the selected slice |
| cmd_col | input | 1 | Slice axis: 0 row, 1 column |
| cmd_idx | input | $clog2(DIM) | Row or column index |
| wr_data | input | DIM*WIDTH | Write lanes in natural element order |
| rd_data | output | DIM*WIDTH | Read lanes in natural element order |
| rd_valid | output | 1 | rd_data holds the result of last cycle's read |

## Verification
The write-then-read assertion assumes that the command inputs are well defined in every cycle after reset. It also assumes that an element is never read before it has been written, because the bank contents start undefined. The stimulus respects this by filling every row before any read is issued. After that, it mixes row and column writes and reads, including combined read-and-write commands, all within whole-slice accesses.

// File: rtl/skew_mtx_pkg.sv
package skew_mtx_pkg;

    typedef enum logic {
        AXIS_ROW = 1'b0,
        AXIS_COL = 1'b1
    } axis_e;

    typedef enum logic {
        PERM_GATHER  = 1'b0,
        PERM_SCATTER = 1'b1
    } perm_dir_e;

    function automatic int wrap_mod(input int v, input int n);
        int r;
        r = v % n;
        if (r < 0) r = r + n;
        return r;
    endfunction

    // Source slot feeding output position pos of a permutation stage.
    // Gather: pos is a lane, result is a bank. Scatter: pos is a bank, result is a lane.
    function automatic int perm_src(input axis_e ax, input perm_dir_e dir,
                                    input int idx, input int pos, input int n);
        int s;
        if (dir == PERM_GATHER)
            s = (ax == AXIS_ROW) ? (pos - idx) : (idx - pos);
        else
            s = (ax == AXIS_ROW) ? (pos + idx) : (idx - pos);
        return wrap_mod(s, n);
    endfunction

    function automatic int bank_row(input axis_e ax, input int idx,
                                    input int bank, input int n);
        return (ax == AXIS_ROW) ? idx : wrap_mod(idx - bank, n);
    endfunction

endpackage

// File: rtl/skew_addr_gen.sv
module skew_addr_gen
    import skew_mtx_pkg::*;
#(
    parameter int DIM = 16,
    localparam int IW = $clog2(DIM)
) (
    input  axis_e          axis,
    input  logic [IW-1:0]  idx,
    output logic [IW-1:0]  addr [DIM]
);

    for (genvar k = 0; k < DIM; k++) begin : g_addr
        always_comb begin
            addr[k] = IW'(bank_row(axis, int'(idx), k, DIM));
        end
    end

endmodule

// File: rtl/lane_permute.sv
module lane_permute
    import skew_mtx_pkg::*;
#(
    parameter int        DIM   = 16,
    parameter int        WIDTH = 32,
    parameter perm_dir_e DIR   = PERM_GATHER,
    localparam int       IW    = $clog2(DIM)
) (
    input  axis_e             axis,
    input  logic [IW-1:0]     idx,
    input  logic [WIDTH-1:0]  din  [DIM],
    output logic [WIDTH-1:0]  dout [DIM]
);

    for (genvar p = 0; p < DIM; p++) begin : g_pos
        logic [IW-1:0] sel;
        always_comb begin
            sel     = IW'(perm_src(axis, DIR, int'(idx), p, DIM));
            dout[p] = din[sel];
        end
    end

endmodule

// File: rtl/mtx_bank.sv
module mtx_bank #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read-first single port: a read in the same cycle as a write sees old data.
    always_ff @(posedge clk) begin
        if (rd) rdata <= mem[addr];
        if (we) mem[addr] <= wdata;
    end

endmodule

// File: rtl/skew_matrix.sv
module skew_matrix
    import skew_mtx_pkg::*;
#(
    parameter int DIM   = 16,
    parameter int WIDTH = 32,
    localparam int IW   = $clog2(DIM),
    localparam int VW   = DIM * WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_rd,
    input  logic           cmd_wr,
    input  logic           cmd_col,
    input  logic [IW-1:0]  cmd_idx,
    input  logic [VW-1:0]  wr_data,
    output logic [VW-1:0]  rd_data,
    output logic           rd_valid
);

    typedef struct packed {
        axis_e         axis;
        logic [IW-1:0] idx;
    } slice_t;

    slice_t cmd_slice, rd_slice;
    assign cmd_slice = '{axis: axis_e'(cmd_col), idx: cmd_idx};

    logic [WIDTH-1:0] lane_in   [DIM];
    logic [WIDTH-1:0] bank_wr   [DIM];
    logic [WIDTH-1:0] bank_rd   [DIM];
    logic [WIDTH-1:0] lane_out  [DIM];
    logic [IW-1:0]    bank_addr [DIM];

    for (genvar j = 0; j < DIM; j++) begin : g_lanes
        assign lane_in[j]                = wr_data[j*WIDTH +: WIDTH];
        assign rd_data[j*WIDTH +: WIDTH] = lane_out[j];
    end

    lane_permute #(.DIM(DIM), .WIDTH(WIDTH), .DIR(PERM_SCATTER)) u_scatter (
        .axis (cmd_slice.axis),
        .idx  (cmd_slice.idx),
        .din  (lane_in),
        .dout (bank_wr)
    );

    skew_addr_gen #(.DIM(DIM)) u_addr (
        .axis (cmd_slice.axis),
        .idx  (cmd_slice.idx),
        .addr (bank_addr)
    );

    for (genvar k = 0; k < DIM; k++) begin : g_bank
        mtx_bank #(.DEPTH(DIM), .WIDTH(WIDTH)) u_bank (
            .clk   (clk),
            .rd    (cmd_rd),
            .we    (cmd_wr),
            .addr  (bank_addr[k]),
            .wdata (bank_wr[k]),
            .rdata (bank_rd[k])
        );
    end

    // Slice context travels with the read so the gather matches the data.
    always_ff @(posedge clk) begin
        if (cmd_rd) rd_slice <= cmd_slice;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= cmd_rd;
    end

    lane_permute #(.DIM(DIM), .WIDTH(WIDTH), .DIR(PERM_GATHER)) u_gather (
        .axis (rd_slice.axis),
        .idx  (rd_slice.idx),
        .din  (bank_rd),
        .dout (lane_out)
    );

endmodule

// File: rtl/skew_matrix_chk.sv
module skew_matrix_chk #(
    parameter int DIM   = 16,
    parameter int WIDTH = 32,
    localparam int IW   = $clog2(DIM),
    localparam int VW   = DIM * WIDTH
) (
    input logic           clk,
    input logic           rst,
    input logic           cmd_rd,
    input logic           cmd_wr,
    input logic           cmd_col,
    input logic [IW-1:0]  cmd_idx,
    input logic [VW-1:0]  wr_data,
    input logic [VW-1:0]  rd_data,
    input logic           rd_valid
);

    logic [1:0] age = 2'd0;
    logic       rst_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst)             age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R8
    rst_clears_valid_chk: assert property (@(posedge clk) rst_q |-> !rd_valid);

    // R5
    read_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> rd_valid);

    // R5
    no_read_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_rd |=> !rd_valid);

    // R7
    idle_holds_data_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd1 && !cmd_rd) |=> $stable(rd_data));

    // R1
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && cmd_rd && $past(cmd_wr) &&
         cmd_col == $past(cmd_col) && cmd_idx == $past(cmd_idx))
        |=> rd_data == $past(wr_data, 2));

endmodule

bind skew_matrix skew_matrix_chk #(.DIM(DIM), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_rd   (cmd_rd),
    .cmd_wr   (cmd_wr),
    .cmd_col  (cmd_col),
    .cmd_idx  (cmd_idx),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/tb_skew_matrix.sv
`timescale 1ns/1ps
module tb_skew_matrix;

    localparam int DIM   = 16;
    localparam int WIDTH = 32;
    localparam int IW    = $clog2(DIM);
    localparam int VW    = DIM * WIDTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_rd = 1'b0;
    logic          cmd_wr = 1'b0;
    logic          cmd_col = 1'b0;
    logic [IW-1:0] cmd_idx = '0;
    logic [VW-1:0] wr_data = '0;
    logic [VW-1:0] rd_data;
    logic          rd_valid;

    always #4 clk = ~clk;

    skew_matrix dut (
        .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_col(cmd_col), .cmd_idx(cmd_idx), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] model [DIM][DIM];
    logic [VW-1:0]    exp_q [$];
    string            tag_q [$];

    function automatic logic [VW-1:0] slice_of(input bit col, input int idx);
        logic [VW-1:0] v;
        for (int j = 0; j < DIM; j++)
            v[j*WIDTH +: WIDTH] = col ? model[j][idx] : model[idx][j];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one command per cycle; expected read data goes to the scoreboard.
    task automatic issue(input bit rd, input bit wr, input bit col, input int idx,
                         input logic [VW-1:0] vec, input string tag);
        @(negedge clk);
        cmd_rd  = rd;
        cmd_wr  = wr;
        cmd_col = col;
        cmd_idx = IW'(idx);
        wr_data = vec;
        if (rd) begin
            exp_q.push_back(slice_of(col, idx));   // old contents (R6)
            tag_q.push_back(tag);
        end
        if (wr)
            for (int j = 0; j < DIM; j++) begin
                if (col) model[j][idx] = vec[j*WIDTH +: WIDTH];
                else     model[idx][j] = vec[j*WIDTH +: WIDTH];
            end
    endtask

    task automatic idle();
        @(negedge clk);
        cmd_rd = 1'b0;
        cmd_wr = 1'b0;
    endtask

    function automatic logic [VW-1:0] pattern(input int salt, input int idx);
        logic [VW-1:0] v;
        for (int j = 0; j < DIM; j++)
            v[j*WIDTH +: WIDTH] = {8'(salt), 8'(idx), 8'(j), 8'(salt ^ (idx * 7 + j))};
        return v;
    endfunction

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int j = 0; j < DIM; j++) v[j*WIDTH +: WIDTH] = $urandom;
        return v;
    endfunction

    // Monitor: compares each delivered slice with the scoreboard head.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected rd_valid", rd_data, '0);
                end else begin
                    logic [VW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(rd_data === e, t, rd_data, e);
                end
            end else if (exp_q.size() != 0) begin
                check(1'b0, "R5 missing rd_valid", '0, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_sim();
    end

    initial begin
        logic [VW-1:0] hold;
        repeat (3) @(posedge clk);
        #1;
        // R8: valid low while in reset
        check(rd_valid === 1'b0, "R8 reset valid", VW'(rd_valid), '0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R10: fill every row, then read them back-to-back
        for (int r = 0; r < DIM; r++) issue(0, 1, 0, r, pattern(1, r), "R1");
        for (int r = 0; r < DIM; r++) issue(1, 0, 0, r, '0, "R1 R10 row read");
        // R3: columns of row-written data
        for (int c = 0; c < DIM; c++) issue(1, 0, 1, c, '0, "R3 column view");
        idle();

        // R2 R4: column write, then every row and the column
        issue(0, 1, 1, 5, pattern(2, 5), "R2");
        for (int r = 0; r < DIM; r++) issue(1, 0, 0, r, '0, "R4 rows after column write");
        issue(1, 0, 1, 5, '0, "R2 column read");
        issue(1, 0, 1, 6, '0, "R4 neighbour column");

        // R6: combined read and write on the same slice
        issue(1, 1, 0, 7, pattern(3, 7), "R6 row old data");
        issue(1, 0, 0, 7, '0, "R6 row new data");
        issue(1, 1, 1, 3, pattern(4, 3), "R6 column old data");
        issue(1, 0, 1, 3, '0, "R6 column new data");
        idle();

        // R7 R9: hold through idle and write-only cycles
        @(posedge clk); #2;
        hold = rd_data;
        issue(0, 1, 0, 9, pattern(5, 9), "R9");
        idle();
        idle();
        @(posedge clk); #2;
        check(rd_valid === 1'b0, "R9 write raised rd_valid", VW'(rd_valid), '0);
        check(rd_data === hold, "R7 R9 rd_data changed", rd_data, hold);
        issue(1, 0, 0, 9, '0, "R9 written row readable");

        // Mixed traffic
        for (int n = 0; n < 400; n++) begin
            bit rd, wr, col;
            int idx;
            rd  = ($urandom % 3) != 0;
            wr  = ($urandom % 2) != 0;
            col = ($urandom % 2) != 0;
            idx = $urandom % DIM;
            if (!rd && !wr) idle();
            else issue(rd, wr, col, idx, rand_vec(), col ? "R2 R3 mixed" : "R1 R3 mixed");
        end
        idle();

        // R8: reset mid-run drops rd_valid
        issue(1, 0, 0, 0, '0, "R1 pre-reset");
        @(negedge clk);
        cmd_rd = 1'b0;
        rst = 1'b1;
        @(posedge clk); #2;
        check(rd_valid === 1'b0, "R8 rd_valid after reset", VW'(rd_valid), '0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) idle();
        check(exp_q.size() == 0, "R5 scoreboard drained", VW'(exp_q.size()), '0);
        finish_sim();
    end

endmodule